// File: doc/BRIEF.md
# Slot-Based Instruction Sequencer for a Four-Register Machine

The block runs programs for a small 16-bit machine with four general registers (A, B, C and D). It reads instruction words from a word-addressed RAM with a combinational read port and handles all control flow itself: halting, no-ops, plain and flag-guarded jumps, subroutine call and return, push and pop, register loads and register stores. Each instruction occupies a two-word slot, so the program counter always advances by two words. A one-word instruction carries a filler word in its second half, and the sequencer reads that word and discards it.

Arithmetic and logic words are not computed here. The block decodes them into an operation code and the two source register values, then presents them on an ALU port for one cycle. It writes the result that comes back into the destination register in that same cycle. Flags come from outside the block. A character output port and a character input port, with a wait-for-valid handshake, serve the terminal instructions. A cycle budget input can stop the machine after a given number of cycles. The stack lives in a reserved region at the top of the address space. Running past either end of it raises a sticky fault and halts the machine.

Top module: `seq_core`

## Requirements
- R1: While reset is held, and after it is released, the program counter and all four registers are zero, `halted` and `stack_fault` are low, and the first fetch reads address 0.
- R2: An instruction that does not wait takes three cycles: fetch of the word at the program counter, read of the following word, then execute. The next fetch is at the program counter plus 2 unless the instruction redirects it.
- R3: Word 0x0000 halts the machine. Any word outside the map below also halts it, without a stack fault. Once `halted` is high it stays high, and the block issues no memory write, character output or ALU request.
- R4: Word 0x0300 does nothing except advance the program counter by 2.
- R5: Word 0x03F1 loads the program counter from the second word of the slot.
- R6: Words 0x03E1, 0x03D1, 0x03C1 and 0x03B1 jump when `flags` bit 0 (zero), bit 1 (negative), bit 2 (overflow) or bit 3 (parity) respectively is 1 in the execute cycle. Otherwise they fall through to the program counter plus 2.
- R7: Word 0x0100 stores the return address (program counter plus 2) on the stack and jumps to the second word. Word 0x0101 pops that address back into the program counter.
- R8: Push is 0x020r and pop is 0x021r. The nibble r is A, B, C or D (0xA to 0xD) and selects the register. The first push writes address 2^AW-1, and each later push writes one word lower.
- R9: Word 0x0Fr0 loads register r with the second word. Word 0x0Fr1 loads register r from the address in the second word. Word 0x0Er1 writes register r to the address in the second word.
- R10: A push or call with STACK_DEPTH words already on the stack, or a pop or return with an empty stack, writes no memory and sets `stack_fault` and `halted` together.
- R11: Word 0xF100 pulses `term_out_valid` for one cycle, with the low 8 bits of the second word on `term_out_char`. Word 0xF000 waits in its execute cycle until `term_in_valid` is high. It then writes the zero-extended `term_in_char` to the address in the second word and pulses `term_in_ack`.
- R12: ALU words pulse `alu_go` for one cycle, with `alu_a` set to the destination register and `alu_b` set to the source register. The unary words are 0x050r (op 0, invert), 0x05Ar (op 1, shift left) and 0x05Br (op 2, shift right). The two-register words are 0xHHds with HH = 06 add (3), 07 sub (4), 08 mul (5), 09 div (6), 0A and (7), 0B or (8), 0C xor (9), 0D copy (10) and 04 compare (11). `alu_res` is written to register d for every op except compare.
- R13: With `cycle_budget` equal to N, the machine halts at the (N+1)-th clock edge after reset if it has not already halted. A value of all ones means no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | RAM word address |
| mem_rdata | input | 16 | RAM read data (combinational) |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 16 | RAM write data |
| flags | input | 4 | Parity, overflow, negative, zero (bit 3 to bit 0) |
| alu_go | output | 1 | ALU request this cycle |
| alu_op | output | 4 | ALU operation code |
| alu_a | output | 16 | Destination register value |
| alu_b | output | 16 | Source register value |
| alu_res | input | 16 | ALU result |
| term_out_valid | output | 1 | Character output strobe |
| term_out_char | output | CHW | Character output data |
| term_in_valid | input | 1 | Input character available |
| term_in_char | input | CHW | Input character data |
| term_in_ack | output | 1 | Input character taken |
| cycle_budget | input | BW | Cycle limit, all ones for none |
| halted | output | 1 | Machine stopped |
| stack_fault | output | 1 | Stack overflow or underflow seen |

## Verification
Every effect is tied to the third cycle of its slot. Writes, character strobes and ALU requests appear during that execute cycle, and `halted` rises at the edge that closes it. A chain of two no-ops and a halt therefore shows `halted` at the ninth edge after reset, and a budget of N shows it at edge N+1. The bench counts edges from the release of reset and samples every output at the falling edge. Strobes are logged in falling-edge monitors. Memory results are read from the bench RAM only after `halted` is seen, so no check lands inside the cycle in which its value changes. The input-wait test holds `term_in_valid` low for 20 cycles and confirms there is no write, no acknowledge and no halt before it releases the character.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [3:0] {
      K_HALT, K_NOP, K_JMP, K_CALL, K_RET, K_PUSH, K_POP,
      K_LDI, K_LDM, K_ST, K_TOUT, K_TIN, K_ALU, K_BAD
   } kind_e;

   typedef enum logic [3:0] {
      OP_NOT, OP_LSH, OP_RSH, OP_ADD, OP_SUB, OP_MUL,
      OP_DIV, OP_AND, OP_OR, OP_XOR, OP_CPY, OP_CMP
   } aluop_e;

   typedef enum logic [2:0] {
      C_ALWAYS, C_ZERO, C_NEG, C_OVF, C_PAR
   } cond_e;

   typedef enum logic [1:0] {
      S_FETCH, S_OPND, S_EXEC, S_HALT
   } state_e;

   typedef struct packed {
      kind_e      kind;
      cond_e      cond;
      logic [1:0] rd;
      logic [1:0] rs;
      aluop_e     aop;
   } dec_t;

   // register letters A..D are nibbles 0xA..0xD
   function automatic logic reg_ok(input logic [3:0] n);
      return (n >= 4'hA) && (n <= 4'hD);
   endfunction

   function automatic logic [1:0] reg_idx(input logic [3:0] n);
      return n[1:0] + 2'd2;
   endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
(
   input  logic [15:0] word,
   output dec_t        dec
);

   logic [3:0] hi_n;
   logic [3:0] lo_n;
   assign hi_n = word[7:4];
   assign lo_n = word[3:0];

   always_comb begin
      dec      = '0;
      dec.kind = K_BAD;
      dec.cond = C_ALWAYS;
      dec.aop  = OP_NOT;
      case (word[15:8])
         8'h00: if (word[7:0] == 8'h00) dec.kind = K_HALT;
         8'h01: begin
            if (word[7:0] == 8'h00) dec.kind = K_CALL;
            else if (word[7:0] == 8'h01) dec.kind = K_RET;
         end
         8'h02: begin
            dec.rd = reg_idx(lo_n);
            if (reg_ok(lo_n) && hi_n == 4'h0) dec.kind = K_PUSH;
            else if (reg_ok(lo_n) && hi_n == 4'h1) dec.kind = K_POP;
         end
         8'h03: begin
            case (word[7:0])
               8'h00: dec.kind = K_NOP;
               8'hF1: begin dec.kind = K_JMP; dec.cond = C_ALWAYS; end
               8'hE1: begin dec.kind = K_JMP; dec.cond = C_ZERO;   end
               8'hD1: begin dec.kind = K_JMP; dec.cond = C_NEG;    end
               8'hC1: begin dec.kind = K_JMP; dec.cond = C_OVF;    end
               8'hB1: begin dec.kind = K_JMP; dec.cond = C_PAR;    end
               default: dec.kind = K_BAD;
            endcase
         end
         8'h05: begin
            dec.rd = reg_idx(lo_n);
            dec.rs = reg_idx(lo_n);
            if (reg_ok(lo_n)) begin
               case (hi_n)
                  4'h0: begin dec.kind = K_ALU; dec.aop = OP_NOT; end
                  4'hA: begin dec.kind = K_ALU; dec.aop = OP_LSH; end
                  4'hB: begin dec.kind = K_ALU; dec.aop = OP_RSH; end
                  default: dec.kind = K_BAD;
               endcase
            end
         end
         8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D: begin
            dec.rd = reg_idx(hi_n);
            dec.rs = reg_idx(lo_n);
            if (reg_ok(hi_n) && reg_ok(lo_n)) begin
               dec.kind = K_ALU;
               case (word[11:8])
                  4'h4: dec.aop = OP_CMP;
                  4'h6: dec.aop = OP_ADD;
                  4'h7: dec.aop = OP_SUB;
                  4'h8: dec.aop = OP_MUL;
                  4'h9: dec.aop = OP_DIV;
                  4'hA: dec.aop = OP_AND;
                  4'hB: dec.aop = OP_OR;
                  4'hC: dec.aop = OP_XOR;
                  default: dec.aop = OP_CPY;
               endcase
            end
         end
         8'h0E: begin
            dec.rd = reg_idx(hi_n);
            if (reg_ok(hi_n) && lo_n == 4'h1) dec.kind = K_ST;
         end
         8'h0F: begin
            dec.rd = reg_idx(hi_n);
            if (reg_ok(hi_n) && lo_n == 4'h0) dec.kind = K_LDI;
            else if (reg_ok(hi_n) && lo_n == 4'h1) dec.kind = K_LDM;
         end
         8'hF0: if (word[7:0] == 8'h00) dec.kind = K_TIN;
         8'hF1: if (word[7:0] == 8'h00) dec.kind = K_TOUT;
         default: dec.kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
   parameter int AW    = 8,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_push,
   input  logic          do_pop,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] push_addr,
   output logic [AW-1:0] pop_addr
);

   localparam int          DW  = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};

   logic [DW-1:0] depth;

   assign full      = (depth == DW'(DEPTH));
   assign empty     = (depth == '0);
   assign push_addr = TOP - AW'(depth);
   assign pop_addr  = push_addr + AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) depth <= '0;
      else if (do_push && !full) depth <= depth + DW'(1);
      else if (do_pop && !empty) depth <= depth - DW'(1);
   end

endmodule

// File: rtl/seq_budget.sv
module seq_budget #(
   parameter int BW = 32,
   parameter bit EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [BW-1:0] budget,
   output logic          spent
);

   generate
      if (EN) begin : g_cnt
         logic [BW-1:0] cnt;
         assign spent = (budget != {BW{1'b1}}) && (cnt == budget);
         always_ff @(posedge clk) begin
            if (!rst_n) cnt <= '0;
            else if (run && !spent) cnt <= cnt + BW'(1);
         end
      end else begin : g_none
         assign spent = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/seq_core.sv
module seq_core
   import seq_pkg::*;
#(
   parameter int AW          = 8,
   parameter int STACK_DEPTH = 8,
   parameter int BW          = 32,
   parameter int CHW         = 8,
   parameter bit BUDGET_EN   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [AW-1:0]  mem_addr,
   input  logic [15:0]    mem_rdata,
   output logic           mem_we,
   output logic [15:0]    mem_wdata,
   input  logic [3:0]     flags,
   output logic           alu_go,
   output logic [3:0]     alu_op,
   output logic [15:0]    alu_a,
   output logic [15:0]    alu_b,
   input  logic [15:0]    alu_res,
   output logic           term_out_valid,
   output logic [CHW-1:0] term_out_char,
   input  logic           term_in_valid,
   input  logic [CHW-1:0] term_in_char,
   output logic           term_in_ack,
   input  logic [BW-1:0]  cycle_budget,
   output logic           halted,
   output logic           stack_fault
);

   localparam logic [AW-1:0] STEP = AW'(2);

   if (AW < 4 || AW > 16) begin : g_chk_aw
      $error("seq_core: AW must lie in 4..16");
   end
   if (STACK_DEPTH < 1 || STACK_DEPTH >= (1 << AW) / 2) begin : g_chk_depth
      $error("seq_core: STACK_DEPTH must fit in half the address space");
   end
   if (CHW < 1 || CHW > 16) begin : g_chk_chw
      $error("seq_core: CHW must lie in 1..16");
   end

   state_e        state;
   logic [AW-1:0] pc;
   logic [15:0]   ir;
   logic [15:0]   opnd;
   logic [15:0]   regs [4];
   logic          fault_q;
   dec_t          dec;
   logic          spent;
   logic          stk_full, stk_empty;
   logic [AW-1:0] stk_push_addr, stk_pop_addr;
   logic [AW-1:0] pc_next;
   logic          in_exec, push_like, pop_like, cond_ok;

   seq_decode i_dec (.word(ir), .dec(dec));

   seq_budget #(.BW(BW), .EN(BUDGET_EN)) i_budget (
      .clk(clk), .rst_n(rst_n), .run(state != S_HALT),
      .budget(cycle_budget), .spent(spent)
   );

   assign in_exec   = (state == S_EXEC) && !spent;
   assign push_like = (dec.kind == K_PUSH) || (dec.kind == K_CALL);
   assign pop_like  = (dec.kind == K_POP)  || (dec.kind == K_RET);
   assign pc_next   = pc + STEP;

   seq_stack #(.AW(AW), .DEPTH(STACK_DEPTH)) i_stack (
      .clk(clk), .rst_n(rst_n),
      .do_push(in_exec && push_like), .do_pop(in_exec && pop_like),
      .full(stk_full), .empty(stk_empty),
      .push_addr(stk_push_addr), .pop_addr(stk_pop_addr)
   );

   always_comb begin
      case (dec.cond)
         C_ALWAYS: cond_ok = 1'b1;
         C_ZERO:   cond_ok = flags[0];
         C_NEG:    cond_ok = flags[1];
         C_OVF:    cond_ok = flags[2];
         C_PAR:    cond_ok = flags[3];
         default:  cond_ok = 1'b0;
      endcase
   end

   always_comb begin
      mem_addr = pc;
      if (state == S_OPND) mem_addr = pc + AW'(1);
      else if (state == S_EXEC) begin
         case (dec.kind)
            K_LDM, K_ST, K_TIN: mem_addr = opnd[AW-1:0];
            K_PUSH, K_CALL:     mem_addr = stk_push_addr;
            K_POP, K_RET:       mem_addr = stk_pop_addr;
            default:            mem_addr = pc;
         endcase
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = regs[dec.rd];
      if (in_exec) begin
         case (dec.kind)
            K_PUSH: mem_we = !stk_full;
            K_CALL: begin mem_we = !stk_full; mem_wdata = 16'(pc_next); end
            K_ST:   mem_we = 1'b1;
            K_TIN:  begin mem_we = term_in_valid; mem_wdata = 16'(term_in_char); end
            default: mem_we = 1'b0;
         endcase
      end
   end

   assign term_out_valid = in_exec && (dec.kind == K_TOUT);
   assign term_out_char  = opnd[CHW-1:0];
   assign term_in_ack    = in_exec && (dec.kind == K_TIN) && term_in_valid;
   assign alu_go         = in_exec && (dec.kind == K_ALU);
   assign alu_op         = dec.aop;
   assign alu_a          = regs[dec.rd];
   assign alu_b          = regs[dec.rs];
   assign halted         = (state == S_HALT);
   assign stack_fault    = fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_FETCH;
         pc      <= '0;
         ir      <= '0;
         opnd    <= '0;
         fault_q <= 1'b0;
         for (int i = 0; i < 4; i++) regs[i] <= '0;
      end else if (state != S_HALT && spent) begin
         state <= S_HALT;
      end else begin
         case (state)
            S_FETCH: begin ir <= mem_rdata; state <= S_OPND; end
            S_OPND:  begin opnd <= mem_rdata; state <= S_EXEC; end
            S_EXEC: begin
               state <= S_FETCH;
               pc    <= pc_next;
               case (dec.kind)
                  K_HALT, K_BAD: begin state <= S_HALT; pc <= pc; end
                  K_JMP: if (cond_ok) pc <= opnd[AW-1:0];
                  K_CALL: begin
                     if (stk_full) begin fault_q <= 1'b1; state <= S_HALT; end
                     else pc <= opnd[AW-1:0];
                  end
                  K_RET: begin
                     if (stk_empty) begin fault_q <= 1'b1; state <= S_HALT; end
                     else pc <= mem_rdata[AW-1:0];
                  end
                  K_PUSH: if (stk_full) begin fault_q <= 1'b1; state <= S_HALT; end
                  K_POP: begin
                     if (stk_empty) begin fault_q <= 1'b1; state <= S_HALT; end
                     else regs[dec.rd] <= mem_rdata;
                  end
                  K_LDI: regs[dec.rd] <= opnd;
                  K_LDM: regs[dec.rd] <= mem_rdata;
                  K_ALU: if (dec.aop != OP_CMP) regs[dec.rd] <= alu_res;
                  K_TIN: if (!term_in_valid) begin state <= S_EXEC; pc <= pc; end
                  default: ;
               endcase
            end
            default: state <= S_HALT;
         endcase
      end
   end

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk (
   input logic clk,
   input logic rst_n,
   input logic halted,
   input logic stack_fault,
   input logic mem_we,
   input logic term_out_valid,
   input logic term_in_ack,
   input logic alu_go
);

   a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   a_r3_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_we && !term_out_valid && !alu_go));

   a_r10_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault |-> halted);

   a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault |=> stack_fault);

   a_r11_ack_writes: assert property (@(posedge clk) disable iff (!rst_n)
      term_in_ack |-> mem_we);

   a_r11_out_single: assert property (@(posedge clk) disable iff (!rst_n)
      term_out_valid |=> !term_out_valid);

   a_r2_write_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   a_r12_alu_alone: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({alu_go, mem_we, term_out_valid}));

endmodule

bind seq_core seq_core_chk i_chk (
   .clk(clk), .rst_n(rst_n), .halted(halted), .stack_fault(stack_fault),
   .mem_we(mem_we), .term_out_valid(term_out_valid),
   .term_in_ack(term_in_ack), .alu_go(alu_go)
);

// File: tb/test_seq_core.sv
`timescale 1ns/1ps
module test_seq_core;

   localparam int AW = 8;
   localparam int SD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_rdata, mem_wdata;
   logic          mem_we;
   logic [3:0]    flags = 4'h0;
   logic          alu_go;
   logic [3:0]    alu_op;
   logic [15:0]   alu_a, alu_b, alu_res;
   logic          term_out_valid, term_in_valid = 1'b0, term_in_ack;
   logic [7:0]    term_out_char, term_in_char = 8'h00;
   logic [31:0]   budget = 32'hFFFF_FFFF;
   logic          halted, stack_fault;

   logic [15:0] mem [256];
   logic [7:0]  outc [64];
   int          out_n = 0;
   int          ack_n = 0;
   int          errors = 0;
   int          checks = 0;

   always #2.5 clk = ~clk;

   seq_core #(.AW(AW), .STACK_DEPTH(SD)) i_seq_core (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .flags(flags),
      .alu_go(alu_go), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
      .alu_res(alu_res), .term_out_valid(term_out_valid),
      .term_out_char(term_out_char), .term_in_valid(term_in_valid),
      .term_in_char(term_in_char), .term_in_ack(term_in_ack),
      .cycle_budget(budget), .halted(halted), .stack_fault(stack_fault)
   );

   assign mem_rdata = mem[mem_addr];
   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

   // external ALU model, op codes per R12
   always_comb begin
      case (alu_op)
         4'd0:  alu_res = ~alu_a;
         4'd1:  alu_res = alu_a << 1;
         4'd2:  alu_res = alu_a >> 1;
         4'd3:  alu_res = alu_a + alu_b;
         4'd4:  alu_res = alu_a - alu_b;
         4'd5:  alu_res = alu_a * alu_b;
         4'd6:  alu_res = (alu_b != 0) ? alu_a / alu_b : 16'h0;
         4'd7:  alu_res = alu_a & alu_b;
         4'd8:  alu_res = alu_a | alu_b;
         4'd9:  alu_res = alu_a ^ alu_b;
         4'd10: alu_res = alu_b;
         default: alu_res = alu_a - alu_b;
      endcase
   end

   always @(negedge clk) begin
      if (term_out_valid) begin
         outc[out_n % 64] <= term_out_char;
         out_n <= out_n + 1;
      end
      if (term_in_ack) ack_n <= ack_n + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [15:0] w0, input logic [15:0] w1);
      mem[a]     = w0;
      mem[a + 1] = w1;
   endtask

   task automatic restart();
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
      budget = 32'hFFFF_FFFF;
      flags = 4'h0;
      term_in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   // releases reset at a falling edge and counts edges until halted
   task automatic run(input int maxc, output int n);
      rst_n = 1'b1;
      n = 0;
      while (!halted && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      restart();
      chk(!halted && !stack_fault, "R1 flags in reset", {halted, stack_fault}, 0);
      put(0, 16'h0EA1, 16'h0080);
      put(2, 16'h0EB1, 16'h0081);
      put(4, 16'h0000, 16'h0000);
      mem[8'h80] = 16'hFFFF;
      mem[8'h81] = 16'hFFFF;
      rst_n = 1'b1;
      chk(mem_addr == 0, "R1 first fetch address", mem_addr, 0);
      begin
         int n;
         run(50, n);
      end
      chk(mem[8'h80] == 0 && mem[8'h81] == 0, "R1 registers zero",
          {mem[8'h80], mem[8'h81]}, 0);
   endtask

   task automatic t_timing();
      int n;
      restart();
      put(0, 16'h0300, 16'h0000);
      put(2, 16'h0300, 16'h0000);
      put(4, 16'h0000, 16'h0000);
      run(50, n);
      chk(n == 9, "R2 R4 three cycles per slot", n, 9);
      chk(halted && !stack_fault, "R3 halt word", {halted, stack_fault}, 2);
      repeat (5) @(negedge clk);
      chk(halted, "R3 halt sticky", halted, 1);
   endtask

   task automatic t_bad();
      int n;
      restart();
      put(0, 16'h0777, 16'h0000);
      put(2, 16'h0EA1, 16'h0080);
      mem[8'h80] = 16'h1234;
      run(50, n);
      chk(n == 3 && !stack_fault, "R3 unknown word halts", n, 3);
      chk(mem[8'h80] == 16'h1234, "R3 no write after bad", mem[8'h80], 16'h1234);
   endtask

   task automatic t_jump();
      int n;
      restart();
      put(0, 16'h03F1, 16'h0010);
      put(2, 16'h0EA1, 16'h0081);
      put(16, 16'h0FA0, 16'h1234);
      put(18, 16'h0EA1, 16'h0080);
      put(20, 16'h0000, 16'h0000);
      mem[8'h81] = 16'h5555;
      run(100, n);
      chk(mem[8'h80] == 16'h1234, "R5 R9 jump target ran", mem[8'h80], 16'h1234);
      chk(mem[8'h81] == 16'h5555, "R5 skipped slot", mem[8'h81], 16'h5555);
   endtask

   task automatic t_cond();
      logic [15:0] code [4];
      code[0] = 16'h03E1; code[1] = 16'h03D1; code[2] = 16'h03C1; code[3] = 16'h03B1;
      for (int i = 0; i < 4; i++) begin
         for (int taken = 0; taken < 2; taken++) begin
            int n;
            restart();
            put(0, code[i], 16'h0010);
            put(2, 16'h0FA0, 16'h0001);
            put(4, 16'h0EA1, 16'h0080);
            put(6, 16'h0000, 16'h0000);
            put(16, 16'h0FA0, 16'h0002);
            put(18, 16'h0EA1, 16'h0080);
            put(20, 16'h0000, 16'h0000);
            flags = (taken != 0) ? 4'(1 << i) : ~4'(1 << i);
            run(100, n);
            chk(mem[8'h80] == ((taken != 0) ? 16'h2 : 16'h1), "R6 conditional jump",
                mem[8'h80], (taken != 0) ? 2 : 1);
         end
      end
   endtask

   task automatic t_stack();
      int n;
      restart();
      put(0, 16'h0FA0, 16'h1111);
      put(2, 16'h0FB0, 16'h2222);
      put(4, 16'h020A, 16'h0300);
      put(6, 16'h020B, 16'h0300);
      put(8, 16'h021C, 16'h0300);
      put(10, 16'h021D, 16'h0300);
      put(12, 16'h0EC1, 16'h0080);
      put(14, 16'h0ED1, 16'h0081);
      put(16, 16'h0000, 16'h0000);
      run(200, n);
      chk(mem[8'h80] == 16'h2222 && mem[8'h81] == 16'h1111, "R8 push pop order",
          {mem[8'h80], mem[8'h81]}, 32'h2222_1111);
      chk(mem[255] == 16'h1111 && mem[254] == 16'h2222, "R8 stack grows down",
          {mem[255], mem[254]}, 32'h1111_2222);
      chk(!stack_fault, "R8 no fault", stack_fault, 0);
   endtask

   task automatic t_call();
      int n;
      restart();
      put(0, 16'h0100, 16'h0020);
      put(2, 16'h0EA1, 16'h0080);
      put(4, 16'h0000, 16'h0000);
      put(32, 16'h0FA0, 16'h4242);
      put(34, 16'h0101, 16'h0000);
      run(100, n);
      chk(mem[8'h80] == 16'h4242, "R7 call and return", mem[8'h80], 16'h4242);
      chk(mem[255] == 16'h0002, "R7 return address", mem[255], 2);
   endtask

   task automatic t_loadmem();
      int n;
      restart();
      put(0, 16'h0FC1, 16'h0090);
      put(2, 16'h0EC1, 16'h0080);
      put(4, 16'h0000, 16'h0000);
      mem[8'h90] = 16'hA5C3;
      run(100, n);
      chk(mem[8'h80] == 16'hA5C3, "R9 load from address", mem[8'h80], 16'hA5C3);
   endtask

   task automatic t_overflow();
      int n;
      restart();
      for (int i = 0; i <= SD; i++) put(2 * i, 16'h020A, 16'h0300);
      put(2 * SD + 2, 16'h0000, 16'h0000);
      mem[255 - SD] = 16'hBEEF;
      run(300, n);
      chk(stack_fault && halted, "R10 overflow fault", {stack_fault, halted}, 3);
      chk(mem[255 - SD] == 16'hBEEF, "R10 no write past limit", mem[255 - SD], 16'hBEEF);
   endtask

   task automatic t_underflow();
      int n;
      restart();
      put(0, 16'h021A, 16'h0300);
      put(2, 16'h0000, 16'h0000);
      run(50, n);
      chk(stack_fault && n == 3, "R10 pop underflow", n, 3);
      restart();
      put(0, 16'h0101, 16'h0000);
      put(2, 16'h0000, 16'h0000);
      run(50, n);
      chk(stack_fault && halted, "R10 return underflow", {stack_fault, halted}, 3);
   endtask

   task automatic t_term();
      int n, base, abase;
      restart();
      put(0, 16'hF100, 16'h0048);
      put(2, 16'hF100, 16'h0169);
      put(4, 16'h0000, 16'h0000);
      base = out_n;
      run(100, n);
      chk(out_n - base == 2, "R11 output count", out_n - base, 2);
      chk(outc[base % 64] == 8'h48 && outc[(base + 1) % 64] == 8'h69, "R11 output chars",
          {outc[base % 64], outc[(base + 1) % 64]}, 16'h4869);
      restart();
      put(0, 16'hF000, 16'h0080);
      put(2, 16'h0000, 16'h0000);
      mem[8'h80] = 16'hFFFF;
      abase = ack_n;
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!halted && mem[8'h80] == 16'hFFFF && ack_n == abase, "R11 input wait",
          mem[8'h80], 16'hFFFF);
      term_in_char  = 8'h41;
      term_in_valid = 1'b1;
      run(50, n);
      chk(mem[8'h80] == 16'h0041 && ack_n - abase == 1, "R11 input stored",
          mem[8'h80], 16'h0041);
   endtask

   task automatic t_alu();
      int n;
      restart();
      put(0, 16'h0FA0, 16'h0005);
      put(2, 16'h0FB0, 16'h0003);
      put(4, 16'h06AB, 16'h0300);
      put(6, 16'h05AB, 16'h0300);
      put(8, 16'h04AB, 16'h0300);
      put(10, 16'h0EA1, 16'h0080);
      put(12, 16'h0EB1, 16'h0081);
      put(14, 16'h0000, 16'h0000);
      run(200, n);
      chk(mem[8'h80] == 16'h0008, "R12 add writes back, compare does not",
          mem[8'h80], 8);
      chk(mem[8'h81] == 16'h0006, "R12 unary shift", mem[8'h81], 6);
   endtask

   task automatic t_budget();
      int n, base;
      restart();
      put(0, 16'hF100, 16'h0078);
      put(2, 16'hF100, 16'h0079);
      put(4, 16'h0000, 16'h0000);
      budget = 32'd3;
      base = out_n;
      run(50, n);
      chk(n == 4 && out_n - base == 1, "R13 budget of three", n, 4);
      restart();
      put(0, 16'hF100, 16'h0078);
      put(2, 16'h0000, 16'h0000);
      budget = 32'd0;
      base = out_n;
      run(50, n);
      chk(n == 1 && out_n - base == 0, "R13 budget of zero", n, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_timing();
      t_bad();
      t_jump();
      t_cond();
      t_stack();
      t_call();
      t_loadmem();
      t_overflow();
      t_underflow();
      t_term();
      t_alu();
      t_budget();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule